// File: doc/BRIEF.md
# Parallel EEPROM page-write sequencer

This block is a clock-sampled behavioural model of a byte-wide nonvolatile memory with an asynchronous, SRAM-like pin interface. Chip enable, output enable and write enable are active low. They pass through a two-flop synchronizer and are edge-detected on the system clock. A read drives the data bus only when the chip is selected, output is enabled and write enable is idle. A write strobe does not change the array directly. Each strobe deposits one byte into a page buffer that marks the bytes it holds with per-byte valid flags.

The first accepted byte of a load window fixes the page. Every later byte must hit that same page and must arrive before an inactivity timer expires. When the timer runs out, the window closes and an internal programming phase begins. This phase lasts a fixed number of cycles. It copies only the flagged bytes into the array and leaves the rest of the page untouched. While it runs, every read returns a status word. Bit 7 of that word is the inverse of bit 7 of the last byte loaded, so software can poll for completion.

Both timers are parameters counted in clock cycles, so a bench can shorten them. The defaults of 7500 and 500000 cycles correspond to about 150 µs and 10 ms at 50 MHz. The address width is a parameter. Fifteen bits gives the full 32,768-byte array. The default keeps the elaborated array small.

Top module: `eeprom_page_model`

## Requirements
- R1: After reset every array byte reads as the erased value 0xFF, and the bus is not driven (`dataOe` low).
- R2: `dataOe` is high only when, after synchronization, chip enable and output enable are low and write enable is high. Any other combination leaves the bus released.
- R3: A write strobe is the interval in which chip enable and write enable are both low while output enable is high. The strobe may be opened and closed by either pin. A strobe with output enable low writes nothing.
- R4: The address is taken when the strobe opens, which is the later of the two falling edges. The data is taken when the strobe closes, which is the earlier of the two rising edges.
- R5: The page buffer holds 2^PAGE_BITS bytes. Address bits [PAGE_BITS-1:0] select the byte within the page and the upper bits select the page. Bytes may arrive in any order, and a byte written twice in one window keeps the later value.
- R6: Programming writes only the bytes loaded in the window. All other bytes of the page keep their previous contents.
- R7: The window closes LOAD_TIMEOUT cycles after the last accepted byte. Before it closes, a read returns the unmodified array contents.
- R8: Programming lasts exactly PROG_CYCLES cycles. Afterwards, reads return the newly stored data.
- R9: During programming, any read returns a status word. Bit 7 is the complement of bit 7 of the last loaded byte, and bits 6:0 are zero.
- R10: A strobe whose page differs from the page fixed by the first byte of the window is ignored.
- R11: Strobes that open during programming are ignored.
- R12: Read data and `dataOe` follow a change on the control pins after exactly three rising clock edges: two synchronizer stages and one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all pins are sampled |
| rstN | input | 1 | Asynchronous active-low reset |
| ceN | input | 1 | Chip enable, active low |
| oeN | input | 1 | Output enable, active low |
| weN | input | 1 | Write enable, active low |
| addr | input | ADDR_W | Byte address |
| dataIn | input | DATA_W | Data from the bus for writes |
| dataOut | output | DATA_W | Read data or status word |
| dataOe | output | 1 | High when the model drives the bus |

## Verification
The assertions check several properties on every cycle:
- the bus is driven only after the right pin combination;
- array writes occur only in the programming phase;
- the page latch and valid flags stay frozen where the rules demand;
- the load window and programming phase never outlive their cycle budgets, and programming exits exactly at its limit.

Other behaviour is visible only through the bench's scenarios and its mirror of the array. These scenarios cover:
- which bytes a window actually changes;
- that later writes win;
- whether the address and data were captured at the right edges;
- the exact value of the status word.

// File: rtl/eeprom_pkg.sv
package eeprom_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_LOAD = 2'd1,
    ST_PROG = 2'd2
  } seqState_t;

  typedef struct packed {
    logic captureAddr;
    logic loadByte;
    logic firstByte;
    logic commitEn;
    logic polling;
  } ctrlStrobes_t;

endpackage

// File: rtl/eeprom_pin_sync.sv
module eeprom_pin_sync #(
  parameter int WIDTH = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] pinsIn,
  output logic [WIDTH-1:0] pinsOut
);

  for (genvar g = 0; g < WIDTH; g++) begin : gStage
    logic meta;
    logic held;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        meta <= 1'b1;
        held <= 1'b1;
      end else begin
        meta <= pinsIn[g];
        held <= meta;
      end
    end
    assign pinsOut[g] = held;
  end

endmodule

// File: rtl/eeprom_seq_ctrl.sv
module eeprom_seq_ctrl
  import eeprom_pkg::*;
#(
  parameter int PAGE_BITS    = 6,
  parameter int LOAD_TIMEOUT = 7500,
  parameter int PROG_CYCLES  = 500000
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 ceS,
  input  logic                 oeS,
  input  logic                 weS,
  input  logic                 pageMatch,
  output ctrlStrobes_t         strobes,
  output logic [PAGE_BITS-1:0] commitIdx,
  output seqState_t            state
);

  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam int LT_W      = $clog2(LOAD_TIMEOUT + 1);
  localparam int PT_W      = $clog2(PROG_CYCLES + 1);
  localparam logic [LT_W-1:0] LT_LAST = LT_W'(LOAD_TIMEOUT - 1);
  localparam logic [PT_W-1:0] PT_LAST = PT_W'(PROG_CYCLES - 1);
  localparam logic [PT_W-1:0] PT_PAGE = PT_W'(PAGE_SIZE);

  logic            wrAct;
  logic            wrActQ;
  logic            armed;
  logic            strobeStart;
  logic            strobeEnd;
  logic            accept;
  logic            loadOk;
  logic [LT_W-1:0] loadTimer;
  logic [PT_W-1:0] progTimer;

  // A write strobe exists while the chip is selected, write enable is low
  // and output enable is high; either edge pin may open or close it.
  assign wrAct       = !ceS && !weS && oeS;
  assign strobeStart = wrAct && !wrActQ;
  assign strobeEnd   = !wrAct && wrActQ;
  assign accept      = strobeEnd && armed && (state != ST_PROG);
  assign loadOk      = accept && ((state == ST_IDLE) || pageMatch);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrActQ    <= 1'b0;
      armed     <= 1'b0;
      state     <= ST_IDLE;
      loadTimer <= '0;
      progTimer <= '0;
    end else begin
      wrActQ <= wrAct;
      if (strobeStart) begin
        armed <= (state != ST_PROG);
      end else if (strobeEnd) begin
        armed <= 1'b0;
      end
      case (state)
        ST_IDLE: begin
          if (loadOk) begin
            state     <= ST_LOAD;
            loadTimer <= '0;
          end
        end
        ST_LOAD: begin
          if (loadOk) begin
            loadTimer <= '0;
          end else if (loadTimer == LT_LAST) begin
            state     <= ST_PROG;
            progTimer <= '0;
          end else begin
            loadTimer <= loadTimer + LT_W'(1);
          end
        end
        ST_PROG: begin
          if (progTimer == PT_LAST) begin
            state <= ST_IDLE;
          end else begin
            progTimer <= progTimer + PT_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobes.captureAddr = strobeStart;
    strobes.loadByte    = loadOk;
    strobes.firstByte   = loadOk && (state == ST_IDLE);
    strobes.commitEn    = (state == ST_PROG) && (progTimer < PT_PAGE);
    strobes.polling     = (state == ST_PROG);
  end

  assign commitIdx = progTimer[PAGE_BITS-1:0];

endmodule

// File: rtl/eeprom_page_dp.sv
module eeprom_page_dp
  import eeprom_pkg::*;
#(
  parameter int ADDR_W    = 11,
  parameter int DATA_W    = 8,
  parameter int PAGE_BITS = 6
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  ctrlStrobes_t                  strobes,
  input  logic [PAGE_BITS-1:0]          commitIdx,
  input  logic [ADDR_W-1:0]             addr,
  input  logic [DATA_W-1:0]             dataIn,
  input  logic                          ceS,
  input  logic                          oeS,
  input  logic                          weS,
  output logic                          pageMatch,
  output logic [DATA_W-1:0]             dataOut,
  output logic                          dataOe,
  output logic [ADDR_W-PAGE_BITS-1:0]   pageReg,
  output logic [(1<<PAGE_BITS)-1:0]     validFlags,
  output logic                          memWe
);

  localparam int DEPTH     = 1 << ADDR_W;
  localparam int PAGE_SIZE = 1 << PAGE_BITS;
  localparam logic [DATA_W-1:0] ERASED = {DATA_W{1'b1}};

  logic [ADDR_W-1:0]    addrLatch;
  logic [PAGE_BITS-1:0] byteOff;
  logic [PAGE_SIZE-1:0] offHot;
  logic [DATA_W-1:0]    lastByte;
  logic [DATA_W-1:0]    pageBuf [PAGE_SIZE];
  logic [DATA_W-1:0]    memArray [DEPTH];
  logic [ADDR_W-1:0]    commitAddr;
  logic [DATA_W-1:0]    pollWord;
  logic [DATA_W-1:0]    readWord;

  assign byteOff    = addrLatch[PAGE_BITS-1:0];
  assign offHot     = {{(PAGE_SIZE-1){1'b0}}, 1'b1} << byteOff;
  assign pageMatch  = (addrLatch[ADDR_W-1:PAGE_BITS] == pageReg);
  assign commitAddr = {pageReg, commitIdx};
  assign memWe      = strobes.commitEn && validFlags[commitIdx];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrLatch <= '0;
    end else if (strobes.captureAddr) begin
      addrLatch <= addr;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pageReg    <= '0;
      validFlags <= '0;
      lastByte   <= '0;
    end else if (strobes.loadByte) begin
      if (strobes.firstByte) begin
        pageReg    <= addrLatch[ADDR_W-1:PAGE_BITS];
        validFlags <= offHot;
      end else begin
        validFlags <= validFlags | offHot;
      end
      lastByte <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (strobes.loadByte) begin
      pageBuf[byteOff] <= dataIn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        memArray[i] <= ERASED;
      end
    end else if (memWe) begin
      memArray[commitAddr] <= pageBuf[commitIdx];
    end
  end

  assign pollWord = {~lastByte[DATA_W-1], {(DATA_W-1){1'b0}}};
  assign readWord = strobes.polling ? pollWord : memArray[addr];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOe  <= 1'b0;
      dataOut <= '0;
    end else begin
      dataOe  <= !ceS && !oeS && weS;
      dataOut <= readWord;
    end
  end

endmodule

// File: rtl/eeprom_page_model.sv
module eeprom_page_model
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int DATA_W       = 8,
  parameter int PAGE_BITS    = 6,
  parameter int LOAD_TIMEOUT = 7500,
  parameter int PROG_CYCLES  = 500000
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              ceN,
  input  logic              oeN,
  input  logic              weN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int PAGE_SIZE = 1 << PAGE_BITS;

  logic [2:0]                  pinsSync;
  logic                        ceS;
  logic                        oeS;
  logic                        weS;
  logic                        pageMatch;
  ctrlStrobes_t                strobes;
  logic [PAGE_BITS-1:0]        commitIdx;
  seqState_t                   ctrlState;
  logic [ADDR_W-PAGE_BITS-1:0] pageReg;
  logic [PAGE_SIZE-1:0]        validFlags;
  logic                        memWe;
  logic                        loadByteW;

  eeprom_pin_sync #(.WIDTH(3)) syncInst (
    .clk     (clk),
    .rstN    (rstN),
    .pinsIn  ({ceN, oeN, weN}),
    .pinsOut (pinsSync)
  );

  assign ceS = pinsSync[2];
  assign oeS = pinsSync[1];
  assign weS = pinsSync[0];

  eeprom_seq_ctrl #(
    .PAGE_BITS    (PAGE_BITS),
    .LOAD_TIMEOUT (LOAD_TIMEOUT),
    .PROG_CYCLES  (PROG_CYCLES)
  ) ctrlInst (
    .clk       (clk),
    .rstN      (rstN),
    .ceS       (ceS),
    .oeS       (oeS),
    .weS       (weS),
    .pageMatch (pageMatch),
    .strobes   (strobes),
    .commitIdx (commitIdx),
    .state     (ctrlState)
  );

  eeprom_page_dp #(
    .ADDR_W    (ADDR_W),
    .DATA_W    (DATA_W),
    .PAGE_BITS (PAGE_BITS)
  ) dpInst (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .commitIdx  (commitIdx),
    .addr       (addr),
    .dataIn     (dataIn),
    .ceS        (ceS),
    .oeS        (oeS),
    .weS        (weS),
    .pageMatch  (pageMatch),
    .dataOut    (dataOut),
    .dataOe     (dataOe),
    .pageReg    (pageReg),
    .validFlags (validFlags),
    .memWe      (memWe)
  );

  assign loadByteW = strobes.loadByte;

endmodule

// File: rtl/eeprom_page_model_chk.sv
module eeprom_page_model_chk
  import eeprom_pkg::*;
#(
  parameter int ADDR_W       = 11,
  parameter int PAGE_BITS    = 6,
  parameter int LOAD_TIMEOUT = 7500,
  parameter int PROG_CYCLES  = 500000
) (
  input logic                        clk,
  input logic                        rstN,
  input logic                        ceN,
  input logic                        oeN,
  input logic                        weN,
  input logic                        dataOe,
  input seqState_t                   state,
  input logic [ADDR_W-PAGE_BITS-1:0] pageReg,
  input logic [(1<<PAGE_BITS)-1:0]   validFlags,
  input logic                        memWe,
  input logic                        loadByte
);

  localparam int LC_W = $clog2(LOAD_TIMEOUT + 2);
  localparam int PC_W = $clog2(PROG_CYCLES + 2);

  logic [LC_W-1:0] idleCnt;
  logic [PC_W-1:0] progCnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idleCnt <= '0;
      progCnt <= '0;
    end else begin
      if (loadByte) begin
        idleCnt <= '0;
      end else if (state == ST_LOAD) begin
        idleCnt <= idleCnt + LC_W'(1);
      end else begin
        idleCnt <= '0;
      end
      if (state == ST_PROG) begin
        progCnt <= progCnt + PC_W'(1);
      end else begin
        progCnt <= '0;
      end
    end
  end

  AST_BUS_DRIVE_GATED: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> (!$past(ceN, 3) && !$past(oeN, 3) && $past(weN, 3))); // R2

  AST_COMMIT_IN_PROG: assert property (@(posedge clk) disable iff (!rstN)
    memWe |-> (state == ST_PROG)); // R6

  AST_WINDOW_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD) |-> (idleCnt < LC_W'(LOAD_TIMEOUT))); // R7

  AST_PROG_LIMIT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG) |-> (progCnt < PC_W'(PROG_CYCLES))); // R8

  AST_PROG_EXACT: assert property (@(posedge clk) disable iff (!rstN)
    ($past(state) == ST_PROG && state != ST_PROG) |-> ($past(progCnt) == PC_W'(PROG_CYCLES - 1))); // R8

  AST_PAGE_HELD: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_LOAD && $past(state) == ST_LOAD) |-> $stable(pageReg)); // R10

  AST_FROZEN_IN_PROG: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PROG && $past(state) == ST_PROG) |-> $stable(validFlags)); // R11

endmodule

bind eeprom_page_model eeprom_page_model_chk #(
  .ADDR_W       (ADDR_W),
  .PAGE_BITS    (PAGE_BITS),
  .LOAD_TIMEOUT (LOAD_TIMEOUT),
  .PROG_CYCLES  (PROG_CYCLES)
) chkInst (
  .clk        (clk),
  .rstN       (rstN),
  .ceN        (ceN),
  .oeN        (oeN),
  .weN        (weN),
  .dataOe     (dataOe),
  .state      (ctrlState),
  .pageReg    (pageReg),
  .validFlags (validFlags),
  .memWe      (memWe),
  .loadByte   (loadByteW)
);

// File: tb/eeprom_page_model_test.sv
module eeprom_page_model_test;

  localparam int AW = 9;
  localparam int DW = 8;
  localparam int PB = 6;
  localparam int LT = 40;
  localparam int PC = 100;
  localparam int PSIZE = 1 << PB;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          ceN = 1'b1;
  logic          oeN = 1'b1;
  logic          weN = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          dataOe;

  int checks = 0;
  int errors = 0;
  logic [DW-1:0] model [DEPTH];

  always #10 clk = ~clk;

  eeprom_page_model #(
    .ADDR_W(AW), .DATA_W(DW), .PAGE_BITS(PB),
    .LOAD_TIMEOUT(LT), .PROG_CYCLES(PC)
  ) uut (
    .clk(clk), .rstN(rstN), .ceN(ceN), .oeN(oeN), .weN(weN),
    .addr(addr), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect8(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic expectBit(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b", req, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] mkAddr(input int page, input int off);
    return AW'(page * PSIZE + off);
  endfunction

  function automatic logic [DW-1:0] pollOf(input logic [DW-1:0] last);
    return last[DW-1] ? 8'h00 : 8'h80;
  endfunction

  task automatic doRead(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic o);
    addr = a; weN = 1'b1; ceN = 1'b0; oeN = 1'b0;
    tick(4);
    d = dataOut; o = dataOe;
    ceN = 1'b1; oeN = 1'b1;
    tick(4);
  endtask

  task automatic readExpect(input string req, input logic [AW-1:0] a, input logic [DW-1:0] exp);
    logic [DW-1:0] d;
    logic o;
    doRead(a, d, o);
    expectBit(req, o, 1'b1);
    expect8(req, d, exp);
  endtask

  task automatic weWrite(input logic [AW-1:0] a, input logic [DW-1:0] d);
    oeN = 1'b1; addr = a; dataIn = d;
    ceN = 1'b0; tick(2);
    weN = 1'b0; tick(5);
    weN = 1'b1; tick(5);
    ceN = 1'b1; tick(2);
  endtask

  task automatic waitDone();
    tick(LT + PC + 30);
  endtask

  task automatic sweepPage(input string req, input int page);
    for (int off = 0; off < PSIZE; off++) begin
      readExpect(req, mkAddr(page, off), model[page * PSIZE + off]);
    end
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual running expected finished");
    finishRun();
  end

  initial begin
    logic [DW-1:0] d;
    logic o;
    logic [DW-1:0] lastVal;
    for (int i = 0; i < DEPTH; i++) model[i] = 8'hFF;

    tick(3);
    rstN = 1'b1;
    tick(2);

    // R1: bus released after reset, erased contents
    expectBit("R1 idle bus", dataOe, 1'b0);
    readExpect("R1 erased", mkAddr(0, 0), 8'hFF);
    readExpect("R1 erased", mkAddr(7, 63), 8'hFF);

    // R12: exact three-edge latency from pins to dataOe
    addr = mkAddr(0, 1); ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    tick(2);
    expectBit("R12 after two edges", dataOe, 1'b0);
    tick(1);
    expectBit("R12 after three edges", dataOe, 1'b1);
    ceN = 1'b1; oeN = 1'b1;
    tick(4);

    // R2: bus gating by pin combination
    ceN = 1'b0; oeN = 1'b1; weN = 1'b1; tick(4);
    expectBit("R2 oe high", dataOe, 1'b0);
    ceN = 1'b1; oeN = 1'b0; tick(4);
    expectBit("R2 ce high", dataOe, 1'b0);
    // R3: output enable low with ce and we low: no drive and no write
    addr = mkAddr(0, 0); dataIn = 8'h42;
    ceN = 1'b0; oeN = 1'b0; weN = 1'b0; tick(4);
    expectBit("R2 we low", dataOe, 1'b0);
    weN = 1'b1; tick(3);
    ceN = 1'b1; oeN = 1'b1; tick(3);
    waitDone();
    readExpect("R3 oe low blocks write", mkAddr(0, 0), 8'hFF);

    // R5: full page, scrambled order
    lastVal = '0;
    for (int i = 0; i < PSIZE; i++) begin
      int off;
      logic [DW-1:0] v;
      off = (i * 37) % PSIZE;
      v = DW'((off * 13 + 5) ^ 8'hC3);
      weWrite(mkAddr(1, off), v);
      model[PSIZE + off] = v;
      lastVal = v;
    end
    // R7: window still open, array unchanged
    readExpect("R7 read inside window", mkAddr(1, 0), 8'hFF);
    tick(LT + 10);
    // R9: status poll during programming
    readExpect("R9 poll word", mkAddr(3, 7), pollOf(lastVal));
    waitDone();
    sweepPage("R5 full page", 1);

    // R6: partial load with overwrite; others keep old data
    weWrite(mkAddr(1, 5), 8'hA5);
    weWrite(mkAddr(1, 9), 8'h3C);
    weWrite(mkAddr(1, 5), 8'h5A);
    model[PSIZE + 5] = 8'h5A;
    model[PSIZE + 9] = 8'h3C;
    // R8: still programming shortly before the limit, data after it
    tick(LT + PC - 30);
    readExpect("R8 busy before end", mkAddr(1, 9), pollOf(8'h5A));
    tick(60);
    readExpect("R8 true data after end", mkAddr(1, 9), 8'h3C);
    sweepPage("R6 selective commit", 1);

    // R10: other page ignored within the window
    weWrite(mkAddr(2, 3), 8'h77);
    weWrite(mkAddr(3, 3), 8'h88);
    weWrite(mkAddr(2, 4), 8'h99);
    model[2 * PSIZE + 3] = 8'h77;
    model[2 * PSIZE + 4] = 8'h99;
    waitDone();
    readExpect("R10 first page byte", mkAddr(2, 3), 8'h77);
    readExpect("R10 later same page byte", mkAddr(2, 4), 8'h99);
    readExpect("R10 foreign page untouched", mkAddr(3, 3), 8'hFF);

    // R11: writes during programming ignored
    weWrite(mkAddr(4, 0), 8'h12);
    model[4 * PSIZE] = 8'h12;
    tick(LT + 15);
    weWrite(mkAddr(4, 1), 8'h34);
    weWrite(mkAddr(5, 0), 8'h56);
    readExpect("R9 poll low bit7 source", mkAddr(4, 0), 8'h80);
    waitDone();
    readExpect("R11 programmed byte", mkAddr(4, 0), 8'h12);
    readExpect("R11 same page ignored", mkAddr(4, 1), 8'hFF);
    readExpect("R11 other page ignored", mkAddr(5, 0), 8'hFF);

    // R3 and R4: strobe opened and closed by chip enable; data at first rise
    oeN = 1'b1; weN = 1'b0; addr = mkAddr(6, 10); dataIn = 8'hD1;
    tick(3);
    ceN = 1'b0; tick(5);
    ceN = 1'b1; tick(5);
    dataIn = 8'hD2; tick(3);
    weN = 1'b1; tick(3);
    model[6 * PSIZE + 10] = 8'hD1;
    waitDone();
    readExpect("R3 ce-controlled write", mkAddr(6, 10), 8'hD1);

    // R4: address taken at the later falling edge only
    oeN = 1'b1; addr = mkAddr(7, 1); dataIn = 8'h00;
    ceN = 1'b0; tick(5);
    addr = mkAddr(7, 2);
    weN = 1'b0; tick(5);
    addr = mkAddr(7, 3); dataIn = 8'h6E; tick(5);
    weN = 1'b1; tick(5);
    ceN = 1'b1; tick(2);
    model[7 * PSIZE + 2] = 8'h6E;
    waitDone();
    readExpect("R4 address at later fall", mkAddr(7, 2), 8'h6E);
    readExpect("R4 early address unused", mkAddr(7, 1), 8'hFF);
    readExpect("R4 late address unused", mkAddr(7, 3), 8'hFF);
    doRead(mkAddr(7, 2), d, o);
    expect8("R1 erased elsewhere", model[0], 8'hFF);

    finishRun();
  end

endmodule